// File: doc/BRIEF.md
# GPIO Port Register Interface

This block is the software-visible register file of a 32-pin general purpose I/O port. A word-wide request bus reaches it. Each request has an enable, a write flag, a byte address and write data. The block holds an output latch, a port-wide direction register, one 32-bit configuration word per pin, and a read-only input register that samples the pin levels. It drives the latch, the direction bits and all configuration words to a separate pin-resolution block. It also raises a one-cycle update strobe after every state-changing write, so that the resolution block can re-evaluate the pins.

The output latch and the direction register each accept three kinds of write: replace, set-only and clear-only. A pin's direction can be seen in two places, the port-wide direction register and bit 0 of that pin's configuration word. The two views always agree. A direction write changes bit 0 of every configuration word, and a configuration write changes that pin's direction bit. Read data is registered and arrives one cycle after the request. An error flag marks any access to an address that is not mapped.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the output latch, direction register and input register are 0, every configuration word reads 0x00000002, and `rsp_rdata`, `rsp_err` and `update_o` are 0.
- R2: A write to 0x504 replaces the output latch. A write to 0x508 ORs the data into it. A write to 0x50C clears the latch bits that are 1 in the data. The new value appears on `out_o` in the cycle after the request.
- R3: The direction register takes the same three write forms at 0x514 (replace), 0x518 (set) and 0x51C (clear), with the result on `dir_o` in the cycle after the request.
- R4: After any direction write, bit 0 of every pin's configuration word equals that pin's new direction bit, and bits 31:1 of every configuration word keep their values.
- R5: A write to 0x700 + 4*i (i from 0 to 31) stores the whole word as configuration word i. It also copies data bit 0 into direction bit i and leaves the other direction bits unchanged.
- R6: Reads of 0x504, 0x508 and 0x50C return the output latch. Reads of 0x514, 0x518 and 0x51C return the direction register. A read of 0x700 + 4*i returns configuration word i, and a read of 0x510 returns the input register.
- R7: The input register takes `pin_level_i` at every clock edge, so a read returns the levels present one edge before the request edge. A write to 0x510 changes no state and gives no update strobe.
- R8: Read data appears on `rsp_rdata` in the cycle after a read request and holds its value through idle cycles and write cycles.
- R9: An access is unmapped if its offset is not one of the addresses above or is not a multiple of 4. For such an access `rsp_err` is 1 in the next cycle only. An unmapped read returns 0, and an unmapped write changes no state. A mapped access leaves `rsp_err` at 0.
- R10: `update_o` is 1 in the cycle after each write to an output, direction or configuration address, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_en | input | 1 | Access request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| pin_level_i | input | 32 | Resolved pin levels to be sampled |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | One-cycle flag for an unmapped access |
| out_o | output | 32 | Output latch |
| dir_o | output | 32 | Direction register, 1 = output |
| cfg_o | output | 1024 | All configuration words, pin i at bits 32*i+31 to 32*i |
| update_o | output | 1 | Re-evaluation strobe after a state-changing write |

## Verification
The properties assume that `req_we` is only meaningful while `req_en` is high. They also assume that the request fields hold steady around the rising edge and that each request is made up of one cycle of enable. They place no condition on `pin_level_i` and no order on writes. The stimulus changes every input half a cycle away from the active edge and raises `req_en` for exactly one cycle per access. It sweeps every mapped address and a set of unaligned and out-of-range offsets, checking a reference model kept in the bench.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

    // register selected by a decoded address
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_OUT,
        SEL_OUTSET,
        SEL_OUTCLR,
        SEL_IN,
        SEL_DIR,
        SEL_DIRSET,
        SEL_DIRCLR,
        SEL_CFG
    } reg_sel_e;

    // byte offsets of the register map
    localparam int unsigned OFS_OUT    = 32'h504;
    localparam int unsigned OFS_OUTSET = 32'h508;
    localparam int unsigned OFS_OUTCLR = 32'h50C;
    localparam int unsigned OFS_IN     = 32'h510;
    localparam int unsigned OFS_DIR    = 32'h514;
    localparam int unsigned OFS_DIRSET = 32'h518;
    localparam int unsigned OFS_DIRCLR = 32'h51C;
    localparam int unsigned OFS_CFG    = 32'h700;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_regs_pkg::*;
#(
    parameter int AW     = 12,
    parameter int NPINS  = 32,
    parameter int PIDX_W = 5
) (
    input  logic [AW-1:0]     addr,
    output reg_sel_e          sel,
    output logic [PIDX_W-1:0] pin
);

    localparam logic [AW-1:0] CFG_BASE = AW'(OFS_CFG);
    localparam logic [AW:0]   CFG_SPAN = (AW+1)'(NPINS * 4);

    logic [AW-1:0] ofs;

    always_comb begin
        ofs = addr - CFG_BASE;
        sel = SEL_NONE;
        pin = '0;
        if (addr[1:0] == 2'b00) begin
            if      (addr == AW'(OFS_OUT))    sel = SEL_OUT;
            else if (addr == AW'(OFS_OUTSET)) sel = SEL_OUTSET;
            else if (addr == AW'(OFS_OUTCLR)) sel = SEL_OUTCLR;
            else if (addr == AW'(OFS_IN))     sel = SEL_IN;
            else if (addr == AW'(OFS_DIR))    sel = SEL_DIR;
            else if (addr == AW'(OFS_DIRSET)) sel = SEL_DIRSET;
            else if (addr == AW'(OFS_DIRCLR)) sel = SEL_DIRCLR;
            else if (addr >= CFG_BASE && {1'b0, ofs} < CFG_SPAN) begin
                sel = SEL_CFG;
                pin = ofs[PIDX_W+1:2];
            end
        end
    end

endmodule

// File: rtl/gpio_port_state.sv
module gpio_port_state
    import gpio_regs_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DW     = 32,
    parameter int PIDX_W = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  reg_sel_e                        sel,
    input  logic [PIDX_W-1:0]               pin,
    input  logic [DW-1:0]                   wdata,
    input  logic [NPINS-1:0]                pin_level,
    output logic [NPINS-1:0]                out_q,
    output logic [NPINS-1:0]                dir_q,
    output logic [NPINS-1:0]                in_q,
    output logic [NPINS-1:0][DW-2:0]        cfg_hi_q,
    output logic                            upd_q
);

    // bit 0 of each configuration word lives only in dir
    localparam logic [DW-2:0] CFG_HI_RST = (DW-1)'(1);

    typedef struct packed {
        logic [NPINS-1:0]         out;
        logic [NPINS-1:0]         dir;
        logic [NPINS-1:0]         in;
        logic [NPINS-1:0][DW-2:0] cfg_hi;
        logic                     upd;
    } st_t;

    st_t st_d, st_q;
    logic [NPINS-1:0] wbits;

    always_comb begin
        wbits     = wdata[NPINS-1:0];
        st_d      = st_q;
        st_d.in   = pin_level;
        st_d.upd  = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_OUT:    begin st_d.out = wbits;                st_d.upd = 1'b1; end
                SEL_OUTSET: begin st_d.out = st_q.out | wbits;     st_d.upd = 1'b1; end
                SEL_OUTCLR: begin st_d.out = st_q.out & ~wbits;    st_d.upd = 1'b1; end
                SEL_DIR:    begin st_d.dir = wbits;                st_d.upd = 1'b1; end
                SEL_DIRSET: begin st_d.dir = st_q.dir | wbits;     st_d.upd = 1'b1; end
                SEL_DIRCLR: begin st_d.dir = st_q.dir & ~wbits;    st_d.upd = 1'b1; end
                SEL_CFG: begin
                    st_d.cfg_hi[pin] = wdata[DW-1:1];
                    st_d.dir[pin]    = wdata[0];
                    st_d.upd         = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{out: '0, dir: '0, in: '0,
                      cfg_hi: {NPINS{CFG_HI_RST}}, upd: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_q    = st_q.out;
    assign dir_q    = st_q.dir;
    assign in_q     = st_q.in;
    assign cfg_hi_q = st_q.cfg_hi;
    assign upd_q    = st_q.upd;

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_regs_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DW     = 32,
    parameter int PIDX_W = 5
) (
    input  reg_sel_e                 sel,
    input  logic [PIDX_W-1:0]        pin,
    input  logic [NPINS-1:0]         out_q,
    input  logic [NPINS-1:0]         dir_q,
    input  logic [NPINS-1:0]         in_q,
    input  logic [NPINS-1:0][DW-2:0] cfg_hi_q,
    output logic [DW-1:0]            rd_word
);

    always_comb begin
        unique case (sel)
            SEL_OUT, SEL_OUTSET, SEL_OUTCLR: rd_word = DW'(out_q);
            SEL_DIR, SEL_DIRSET, SEL_DIRCLR: rd_word = DW'(dir_q);
            SEL_IN:                          rd_word = DW'(in_q);
            SEL_CFG:                         rd_word = {cfg_hi_q[pin], dir_q[pin]};
            default:                         rd_word = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_regs_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int DW    = 32,
    parameter int AW    = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_en,
    input  logic                  req_we,
    input  logic [AW-1:0]         req_addr,
    input  logic [DW-1:0]         req_wdata,
    input  logic [NPINS-1:0]      pin_level_i,
    output logic [DW-1:0]         rsp_rdata,
    output logic                  rsp_err,
    output logic [NPINS-1:0]      out_o,
    output logic [NPINS-1:0]      dir_o,
    output logic [NPINS*DW-1:0]   cfg_o,
    output logic                  update_o
);

    localparam int PIDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          err;
    } rsp_t;

    reg_sel_e                 sel;
    logic [PIDX_W-1:0]        pin;
    logic [NPINS-1:0]         out_q, dir_q, in_q;
    logic [NPINS-1:0][DW-2:0] cfg_hi_q;
    logic [DW-1:0]            rd_word;
    logic                     upd_q;
    rsp_t                     rsp_d, rsp_q;

    gpio_addr_decode #(.AW(AW), .NPINS(NPINS), .PIDX_W(PIDX_W)) dec_i (
        .addr (req_addr),
        .sel  (sel),
        .pin  (pin)
    );

    gpio_port_state #(.NPINS(NPINS), .DW(DW), .PIDX_W(PIDX_W)) state_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (req_en && req_we),
        .sel       (sel),
        .pin       (pin),
        .wdata     (req_wdata),
        .pin_level (pin_level_i),
        .out_q     (out_q),
        .dir_q     (dir_q),
        .in_q      (in_q),
        .cfg_hi_q  (cfg_hi_q),
        .upd_q     (upd_q)
    );

    gpio_read_mux #(.NPINS(NPINS), .DW(DW), .PIDX_W(PIDX_W)) rmux_i (
        .sel      (sel),
        .pin      (pin),
        .out_q    (out_q),
        .dir_q    (dir_q),
        .in_q     (in_q),
        .cfg_hi_q (cfg_hi_q),
        .rd_word  (rd_word)
    );

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.err = req_en && (sel == SEL_NONE);
        if (req_en && !req_we) begin
            rsp_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_cfg_out
        assign cfg_o[g*DW +: DW] = {cfg_hi_q[g], dir_q[g]};
    end

    assign rsp_rdata = rsp_q.rdata;
    assign rsp_err   = rsp_q.err;
    assign out_o     = out_q;
    assign dir_o     = dir_q;
    assign update_o  = upd_q;

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
    import gpio_regs_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int DW    = 32,
    parameter int AW    = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_en,
    input logic                req_we,
    input logic [AW-1:0]       req_addr,
    input logic [DW-1:0]       req_wdata,
    input logic [DW-1:0]       rsp_rdata,
    input logic                rsp_err,
    input logic [NPINS-1:0]    out_o,
    input logic [NPINS-1:0]    dir_o,
    input logic [NPINS*DW-1:0] cfg_o,
    input logic                update_o
);

    logic wr, rd;
    assign wr = req_en && req_we;
    assign rd = req_en && !req_we;

    // R2
    out_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && req_addr == AW'(OFS_OUT) |=> out_o == $past(req_wdata[NPINS-1:0]));
    // R2
    out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && req_addr == AW'(OFS_OUTSET) |=> out_o == ($past(out_o) | $past(req_wdata[NPINS-1:0])));
    // R2
    out_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && req_addr == AW'(OFS_OUTCLR) |=> out_o == ($past(out_o) & ~$past(req_wdata[NPINS-1:0])));
    // R3
    dir_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && req_addr == AW'(OFS_DIR) |=> dir_o == $past(req_wdata[NPINS-1:0]));
    // R3
    dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && req_addr == AW'(OFS_DIRSET) |=> dir_o == ($past(dir_o) | $past(req_wdata[NPINS-1:0])));
    // R5
    cfg0_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && req_addr == AW'(OFS_CFG) |=> cfg_o[DW-1:0] == $past(req_wdata) && dir_o[0] == $past(req_wdata[0]));
    // R10
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(out_o) && $stable(dir_o) && $stable(cfg_o) && !update_o);
    // R9
    unaligned_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_en && req_addr[1:0] != 2'b00 |=> rsp_err);
    // R9
    unaligned_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd && req_addr[1:0] != 2'b00 |=> rsp_rdata == '0);
    // R9
    idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_en |=> !rsp_err);
    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rsp_rdata));

endmodule

bind gpio_port_regs gpio_port_regs_chk #(.NPINS(NPINS), .DW(DW), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_en    (req_en),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .out_o     (out_o),
    .dir_o     (dir_o),
    .cfg_o     (cfg_o),
    .update_o  (update_o)
);

// File: tb/gpio_port_regs_tb_top.sv
module gpio_port_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;

    localparam logic [11:0] A_OUT = 12'h504, A_OSET = 12'h508, A_OCLR = 12'h50C;
    localparam logic [11:0] A_IN  = 12'h510;
    localparam logic [11:0] A_DIR = 12'h514, A_DSET = 12'h518, A_DCLR = 12'h51C;
    localparam logic [11:0] A_CFG = 12'h700;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_en = 1'b0, req_we = 1'b0;
    logic [11:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   pin_level_i = '0;
    logic [31:0]   rsp_rdata;
    logic          rsp_err;
    logic [31:0]   out_o, dir_o;
    logic [1023:0] cfg_o;
    logic          update_o;

    int errors = 0;
    int checks = 0;

    logic [31:0] out_m, dir_m;
    logic [31:0] cfg_m [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_regs dut_i (
        .clk, .rst_n, .req_en, .req_we, .req_addr, .req_wdata, .pin_level_i,
        .rsp_rdata, .rsp_err, .out_o, .dir_o, .cfg_o, .update_o
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_en = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_en = 1'b0; req_we = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        req_en = 1'b1; req_we = 1'b0; req_addr = a;
        @(negedge clk);
        req_en = 1'b0;
        d = rsp_rdata;
        e = rsp_err;
    endtask

    // model update for a mapped write
    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        case (a)
            A_OUT:  out_m = d;
            A_OSET: out_m = out_m | d;
            A_OCLR: out_m = out_m & ~d;
            A_DIR:  dir_m = d;
            A_DSET: dir_m = dir_m | d;
            A_DCLR: dir_m = dir_m & ~d;
            default: ;
        endcase
        if (a >= A_CFG && a < A_CFG + 12'd128) begin
            cfg_m[(a - A_CFG) >> 2] = d;
            dir_m[(a - A_CFG) >> 2] = d[0];
        end
        for (int i = 0; i < NP; i++) cfg_m[i][0] = dir_m[i];
    endtask

    task automatic check_all_cfg(input string req);
        for (int i = 0; i < NP; i++) chk(req, cfg_o[i*32 +: 32], cfg_m[i]);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        logic [31:0] rd, pat;
        logic        er;
        logic [11:0] waddr [6];
        logic [11:0] bad   [8];
        waddr = '{A_OUT, A_OSET, A_OCLR, A_DIR, A_DSET, A_DCLR};
        bad   = '{12'h000, 12'h500, 12'h520, 12'h6FC, 12'h780, 12'h506, 12'h701, 12'hFFC};

        out_m = '0; dir_m = '0;
        for (int i = 0; i < NP; i++) cfg_m[i] = 32'h2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out", out_o, 32'h0);
        chk("R1 dir", dir_o, 32'h0);
        chk("R1 update", {31'h0, update_o}, 32'h0);
        chk("R1 err", {31'h0, rsp_err}, 32'h0);
        chk("R1 rdata", rsp_rdata, 32'h0);
        check_all_cfg("R1 cfg");
        do_read(A_IN, rd, er);
        chk("R1 in", rd, 32'h0);

        // R2 R3 R4 R6 R10: sweep every alias with arithmetic patterns
        for (int k = 0; k < 8; k++) begin
            pat = (32'h9E3779B9 * (k + 1)) ^ (32'h1 << (k * 4));
            for (int w = 0; w < 6; w++) begin
                do_write(waddr[w], pat);
                model_write(waddr[w], pat);
                chk("R2 out_o", out_o, out_m);
                chk("R3 dir_o", dir_o, dir_m);
                chk("R10 update after write", {31'h0, update_o}, 32'h1);
                check_all_cfg("R4 cfg reflect");
                for (int r = 0; r < 6; r++) begin
                    do_read(waddr[r], rd, er);
                    chk("R6 alias read", rd, (r < 3) ? out_m : dir_m);
                    chk("R9 mapped no err", {31'h0, er}, 32'h0);
                end
                chk("R10 idle no update", {31'h0, update_o}, 32'h0);
            end
        end

        // R5 configuration words, each pin
        for (int i = 0; i < NP; i++) begin
            pat = (32'hA5C3_0F1E ^ (i * 32'h0101_0101)) + i;
            do_write(A_CFG + 12'(i * 4), pat);
            model_write(A_CFG + 12'(i * 4), pat);
            chk("R5 dir_o", dir_o, dir_m);
            chk("R5 cfg_o word", cfg_o[i*32 +: 32], pat);
            chk("R10 cfg update", {31'h0, update_o}, 32'h1);
            do_read(A_CFG + 12'(i * 4), rd, er);
            chk("R6 cfg read", rd, pat);
        end
        // R4 upper bits survive a direction write
        do_write(A_DIR, 32'h0F0F_3C3C);
        model_write(A_DIR, 32'h0F0F_3C3C);
        check_all_cfg("R4 upper kept");
        do_write(A_DCLR, 32'hFFFF_0000);
        model_write(A_DCLR, 32'hFFFF_0000);
        check_all_cfg("R4 clear reflect");
        chk("R3 dirclr", dir_o, dir_m);

        // R7 input sampling, one edge of latency
        pin_level_i = 32'hDEAD_BEEF;
        @(negedge clk);
        do_read(A_IN, rd, er);
        chk("R7 in read", rd, 32'hDEAD_BEEF);
        @(negedge clk);
        req_en = 1'b1; req_we = 1'b0; req_addr = A_IN;
        pin_level_i = 32'h1234_5678;
        @(negedge clk);
        req_en = 1'b0;
        chk("R7 in old level", rsp_rdata, 32'hDEAD_BEEF);
        do_write(A_IN, 32'hFFFF_FFFF);
        chk("R7 in write no update", {31'h0, update_o}, 32'h0);
        chk("R7 in write out", out_o, out_m);
        chk("R7 in write dir", dir_o, dir_m);
        do_read(A_IN, rd, er);
        chk("R7 in after write", rd, 32'h1234_5678);

        // R8 read data holds
        do_read(A_OUT, rd, er);
        repeat (3) @(negedge clk);
        chk("R8 hold idle", rsp_rdata, out_m);
        do_write(A_OSET, 32'h0000_0001);
        model_write(A_OSET, 32'h0000_0001);
        chk("R8 hold on write", rsp_rdata, rd);

        // R9 unmapped offsets
        for (int b = 0; b < 8; b++) begin
            do_read(bad[b], rd, er);
            chk("R9 unmapped read zero", rd, 32'h0);
            chk("R9 unmapped read err", {31'h0, er}, 32'h1);
            do_write(bad[b], 32'hFFFF_FFFF);
            chk("R9 unmapped write err", {31'h0, rsp_err}, 32'h1);
            chk("R9 unmapped write update", {31'h0, update_o}, 32'h0);
            chk("R9 unmapped write out", out_o, out_m);
            chk("R9 unmapped write dir", dir_o, dir_m);
            check_all_cfg("R9 unmapped write cfg");
            @(negedge clk);
            chk("R9 err one cycle", {31'h0, rsp_err}, 32'h0);
        end

        summary();
    end

endmodule